// File: doc/BRIEF.md
# Watchdog and Supervisory Reset Generator

This block drives a single active-low system reset pin from three causes: the power-on indication, a low-supply flag from an external comparator, and an internal watchdog timer. The pin is open-drain in style. The block only asks for it to be pulled low or lets it go, and an external pull-up gives the high level. The output `rst_pull_low` is the pull-down enable: 1 pulls the pin low and 0 releases it.

The watchdog counts clock cycles while reset is released. A falling edge on the chip-select/watchdog-input line (`cs_wdi`) restarts the count. This lets a host keep the system alive just by using its serial bus. A 2-bit select picks one of three timeout lengths, or switches the watchdog off. Each timeout length is a cycle count given by a parameter. When a timeout expires, or when the supply is low, or at power-up, the reset is held for a fixed stretch of `RST_CYC` cycles and then released. After that the watchdog starts counting again from zero.

Top module: `wdr_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_pull_low` is 1. After `por_n` rises, `rst_pull_low` stays 1 for exactly `RST_CYC` clock edges and is then 0.
- R2: With reset released and no activity, `rst_pull_low` rises after exactly T clock edges. T is `T_LONG` for select `2'b00`, `T_MID` for `2'b01` and `T_SHORT` for `2'b10`.
- R3: Select `2'b11` turns the watchdog off. With a good supply, reset then stays released however long `cs_wdi` is idle.
- R4: A falling edge on `cs_wdi` passes through a two-flop synchronizer and an edge detector. It clears the count on the third clock edge after the fall, so the next timeout comes T+3 edges after the fall. A rising edge on `cs_wdi` has no effect.
- R5: A change of `wd_sel` clears the count on the next clock edge, so the new timeout comes T+1 edges after the change.
- R6: A watchdog timeout holds `rst_pull_low` at 1 for exactly `RST_CYC` edges. The count then restarts from zero and a full T elapses before the next timeout.
- R7: A rising `vcc_low` sets `rst_pull_low` on the third clock edge. Reset stays set for as long as `vcc_low` is high, and is released `RST_CYC`+2 edges after `vcc_low` falls.
- R8: `cs_wdi` activity while reset is held neither shortens nor lengthens the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Raw power-on indication, asynchronous, low while power is not yet good |
| vcc_low | input | 1 | Supply-below-trip flag from the external comparator, asynchronous |
| cs_wdi | input | 1 | Chip-select / watchdog activity line, asynchronous, idles high |
| wd_sel | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 off |
| rst_pull_low | output | 1 | 1 pulls the reset pin low; 0 releases it to the pull-up |

## Verification
Some properties are checked by assertions on every cycle. These are:
- every expiry loads the full hold stretch;
- a detected edge or a select change empties the count;
- the off setting never produces an expiry;
- a supply flag that stays up keeps the pin pulled;
- the pin is released only when the hold counter reaches its last cycle.

The exact cycle counts can only be shown by the bench scenarios. These are the power-up stretch, each of the three timeouts, the three-stage delay of a kick, the T+1 after a select change and the tail after the supply recovers. The same holds for showing that a rising `cs_wdi` edge or a kick during a hold changes nothing.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdr_sync.sv
module wdr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain[0] <= RST_VAL;
    else         chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[i] <= RST_VAL;
      else         chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdr_fall_det.sv
module wdr_fall_det (
  input  logic clk,
  input  logic arst_n,
  input  logic lvl,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev <= 1'b1;
    else         prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/wdr_wd_timer.sv
module wdr_wd_timer
  import wdr_pkg::*;
#(
  parameter int T_LONG  = 1400,
  parameter int T_MID   = 600,
  parameter int T_SHORT = 200,
  parameter int CW      = 11
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [1:0]    sel,
  input  logic          kick,
  input  logic          hold,
  output logic          expire,
  output logic [CW-1:0] cnt
);
  logic [1:0]    sel_q;
  logic          sel_chg;
  logic          enabled;
  logic [CW-1:0] last_val;
  logic          restart;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sel_q <= 2'b00;
    else         sel_q <= sel;
  end

  assign sel_chg = (sel != sel_q);

  always_comb begin
    enabled  = 1'b1;
    last_val = CW'(T_LONG - 1);
    case (wd_sel_e'(sel))
      WD_LONG:  last_val = CW'(T_LONG - 1);
      WD_MID:   last_val = CW'(T_MID - 1);
      WD_SHORT: last_val = CW'(T_SHORT - 1);
      default:  enabled  = 1'b0;
    endcase
  end

  assign restart = hold | ~enabled | kick | sel_chg;
  assign expire  = ~restart & (cnt == last_val);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               cnt <= '0;
    else if (restart | expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdr_hold.sv
module wdr_hold #(
  parameter int RST_CYC = 64,
  parameter int HW      = 7
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          trig,
  output logic [HW-1:0] hold_cnt,
  output logic          active
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               hold_cnt <= HW'(RST_CYC);
    else if (trig)             hold_cnt <= HW'(RST_CYC);
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
  end

  assign active = (hold_cnt != '0);
endmodule

// File: rtl/wdr_supervisor.sv
module wdr_supervisor
  import wdr_pkg::*;
#(
  parameter int T_LONG   = 1400,
  parameter int T_MID    = 600,
  parameter int T_SHORT  = 200,
  parameter int RST_CYC  = 64,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       vcc_low,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       rst_pull_low
);
  localparam int TMAX = max3(T_LONG, T_MID, T_SHORT);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int HW   = $clog2(RST_CYC + 1);

  logic          cs_s;
  logic          vcc_s;
  logic          kick;
  logic          expire;
  logic          hold_on;
  logic [CW-1:0] wd_cnt;
  logic [HW-1:0] hold_cnt;

  wdr_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .arst_n(por_n), .d(cs_wdi), .q(cs_s)
  );

  wdr_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_vcc_sync (
    .clk(clk), .arst_n(por_n), .d(vcc_low), .q(vcc_s)
  );

  wdr_fall_det u_fall (
    .clk(clk), .arst_n(por_n), .lvl(cs_s), .fall(kick)
  );

  wdr_wd_timer #(
    .T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT), .CW(CW)
  ) u_timer (
    .clk(clk), .arst_n(por_n), .sel(wd_sel), .kick(kick),
    .hold(hold_on), .expire(expire), .cnt(wd_cnt)
  );

  wdr_hold #(.RST_CYC(RST_CYC), .HW(HW)) u_hold (
    .clk(clk), .arst_n(por_n), .trig(vcc_s | expire),
    .hold_cnt(hold_cnt), .active(hold_on)
  );

  assign rst_pull_low = hold_on;
endmodule

// File: rtl/wdr_supervisor_chk.sv
module wdr_supervisor_chk #(
  parameter int TMAX    = 1400,
  parameter int RST_CYC = 64,
  parameter int CW      = 11,
  parameter int HW      = 7
) (
  input logic          clk,
  input logic          por_n,
  input logic          vcc_low,
  input logic [1:0]    wd_sel,
  input logic          rst_pull_low,
  input logic          expire,
  input logic          kick,
  input logic [CW-1:0] wd_cnt,
  input logic [HW-1:0] hold_cnt
);
  AST_EXPIRE_LOADS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> (rst_pull_low && hold_cnt == HW'(RST_CYC))); // R6

  AST_KICK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> (wd_cnt == '0)); // R4

  AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sel != $past(wd_sel)) |=> (wd_cnt == '0)); // R5

  AST_OFF_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sel == 2'b11 && $past(wd_sel) == 2'b11) |-> !expire); // R3

  AST_SUPPLY_LOW_PULLS: assert property (@(posedge clk) disable iff (!por_n)
    (vcc_low && $past(vcc_low) && $past(vcc_low, 2)) |=> rst_pull_low); // R7

  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_pull_low) |-> ($past(hold_cnt) == HW'(1))); // R8

  AST_NO_EXPIRE_IN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    rst_pull_low |-> !expire); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    wd_cnt <= CW'(TMAX - 1)); // R2
endmodule

bind wdr_supervisor wdr_supervisor_chk #(
  .TMAX(TMAX), .RST_CYC(RST_CYC), .CW(CW), .HW(HW)
) u_chk (
  .clk(clk), .por_n(por_n), .vcc_low(vcc_low), .wd_sel(wd_sel),
  .rst_pull_low(rst_pull_low), .expire(expire), .kick(kick),
  .wd_cnt(wd_cnt), .hold_cnt(hold_cnt)
);

// File: tb/wdr_supervisor_tb.sv
`timescale 1ns/1ps
module wdr_supervisor_tb;
  localparam int TL = 300;
  localparam int TM = 200;
  localparam int TS = 100;
  localparam int RC = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       vcc_low = 1'b0;
  logic       cs_wdi = 1'b1;
  logic [1:0] wd_sel = 2'b00;
  logic       rst_pull_low;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  wdr_supervisor #(
    .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_CYC(RC)
  ) u_dut (
    .clk(clk), .por_n(por_n), .vcc_low(vcc_low), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .rst_pull_low(rst_pull_low)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(inout int n);
    @(posedge clk);
    #1;
    n++;
  endtask

  task automatic wait_level(input logic lvl, inout int n);
    int lim;
    lim = n + 4 * TL;
    do tick(n); while (rst_pull_low !== lvl && n < lim);
  endtask

  task automatic t_power_up();
    int n = 0;
    repeat (5) tick(n);
    check("R1 pulled during por", int'(rst_pull_low), 1);
    @(negedge clk);
    por_n = 1'b1;
    n = 0;
    wait_level(1'b0, n);
    check("R1 power-up stretch", n, RC);
  endtask

  task automatic t_long_restart();
    int n = 0;
    wait_level(1'b1, n);
    check("R2 long timeout", n, TL);
    n = 0;
    wait_level(1'b0, n);
    check("R6 hold after timeout", n, RC);
    n = 0;
    wait_level(1'b1, n);
    check("R6 count restarts", n, TL);
    n = 0;
    cs_wdi = 1'b0;
    repeat (3) tick(n);
    cs_wdi = 1'b1;
    wait_level(1'b0, n);
    check("R8 kick during hold", n, RC);
  endtask

  task automatic t_short_sel();
    int n = 0;
    repeat (10) tick(n);
    wd_sel = 2'b10;
    n = 0;
    wait_level(1'b1, n);
    check("R5 short after change", n, TS + 1);
    n = 0;
    wait_level(1'b0, n);
    check("R6 hold short", n, RC);
  endtask

  task automatic t_mid_sel();
    int n = 0;
    wd_sel = 2'b01;
    wait_level(1'b1, n);
    check("R2 mid after change", n, TM + 1);
    n = 0;
    wait_level(1'b0, n);
    check("R6 hold mid", n, RC);
  endtask

  task automatic t_kick();
    int n = 0;
    repeat (50) tick(n);
    cs_wdi = 1'b0;
    n = 0;
    repeat (4) tick(n);
    cs_wdi = 1'b1;
    wait_level(1'b1, n);
    check("R4 kick restarts count", n, TM + 3);
    n = 0;
    wait_level(1'b0, n);
    check("R6 hold after kick run", n, RC);
  endtask

  task automatic t_disabled();
    int n = 0;
    int highs = 0;
    wd_sel = 2'b11;
    repeat (3 * TL) begin
      tick(n);
      if (rst_pull_low) highs++;
    end
    check("R3 off never resets", highs, 0);
  endtask

  task automatic t_supply();
    int n = 0;
    int lows = 0;
    @(negedge clk);
    vcc_low = 1'b1;
    wait_level(1'b1, n);
    check("R7 supply-low latency", n, 3);
    n = 0;
    repeat (40) begin
      tick(n);
      if (!rst_pull_low) lows++;
    end
    check("R7 held while low", lows, 0);
    @(negedge clk);
    vcc_low = 1'b0;
    n = 0;
    wait_level(1'b0, n);
    check("R7 tail after recovery", n, RC + 2);
  endtask

  initial begin
    t_power_up();
    t_long_restart();
    t_short_sel();
    t_mid_sel();
    t_kick();
    t_disabled();
    t_supply();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule